// File: doc/BRIEF.md
# LCD Pixel Fetch and Grayscale Mapper

This block sits between the frame-buffer DMA engine and the panel timing logic of an LCD controller. It keeps 32-bit frame-buffer words in a small word queue. It asks the DMA engine for more data whenever the queue runs low. Each word is split into pixels of 1, 2 or 4 bits, starting at the least significant end. Each pixel goes through a sixteen-entry palette and comes out as a 4-bit gray level.

The panel timing logic sends one advance strobe per displayed pixel. The current gray value is shown on the output until that strobe arrives. A low-power snooze input skips the palette and shows the raw pixel code instead. The control word holds an enable bit and a pixel-depth field. The depth field only changes while the block is disabled. Turning the block off empties the queue and returns to the start of a word.

Top module: `lcd_pixfetch`

## Requirements
- R1: After reset, dma_req is 0, gray is 0 and underrun is 0.
- R2: The queue holds up to 9 words. A word written while the queue is full is discarded, and a word written while the block is disabled is also discarded.
- R3: dma_req is 1 exactly when the block is enabled and the queue holds 5 words or fewer.
- R4: Pixel k of a word is taken from bits [k*b +: b], where b is the pixel width. Pixel 0 is therefore at the least significant end.
- R5: Depth code 2'b00 selects 1 bit per pixel (32 pixels per word), and code 2'b01 selects 2 bits per pixel (16 pixels per word).
- R6: Depth codes 2'b10 and 2'b11 both select 4 bits per pixel (8 pixels per word).
- R7: When snooze is 0, gray equals palette entry p, where p is the pixel value. Entry n is bits [4n+3:4n] of the 64-bit value {pal_hi, pal_lo}.
- R8: When snooze is 1, the palette is skipped and gray equals the pixel value extended with zeros to 4 bits.
- R9: A control write while enabled updates only the enable bit. The depth field keeps its value.
- R10: When pix_adv arrives on the last pixel of a word, that word is removed from the queue. The next pixel then comes from bit 0 of the following word, with no gap.
- R11: When the queue is empty, gray is 0. A pix_adv while enabled and empty sets underrun, and underrun stays at 1 until reset.
- R12: Clearing the enable bit empties the queue, forces dma_req to 0 and returns the pixel position to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_we | input | 1 | Control word write strobe |
| cfg_enable | input | 1 | Enable bit of the control word |
| cfg_bpp | input | 2 | Pixel depth code of the control word |
| pal_lo_we | input | 1 | Write strobe for palette entries 0 to 7 |
| pal_lo_data | input | 32 | Palette entries 0 to 7 |
| pal_hi_we | input | 1 | Write strobe for palette entries 8 to 15 |
| pal_hi_data | input | 32 | Palette entries 8 to 15 |
| snooze | input | 1 | Skip the palette |
| wr_valid | input | 1 | Frame-buffer word valid |
| wr_data | input | 32 | Frame-buffer word |
| dma_req | output | 1 | Request for more words |
| pix_adv | input | 1 | Move to the next pixel |
| gray | output | 4 | Gray level of the current pixel |
| underrun | output | 1 | Sticky flag: a pixel was requested from an empty queue |

## Verification
The bench uses the default depth of 9 and low-water mark of 5. With these values, the full queue, the dropped tenth word and both sides of the request threshold are reached within a few dozen cycles. The bench fills the queue to capacity, then drains it one word at a time. It checks the request line at fill levels 9, 6 and 5. This shows the boundary between 5 and 6 words, not just an empty or full queue. Every pixel depth is run across a word boundary, with and without snooze.

// File: rtl/lcd_pix_pkg.sv
package lcd_pix_pkg;

  typedef enum logic [1:0] {
    BPP_1   = 2'b00,
    BPP_2   = 2'b01,
    BPP_4   = 2'b10,
    BPP_4_X = 2'b11
  } bpp_e;

  // highest pixel position inside a 32-bit word for a given depth
  function automatic logic [4:0] last_pos(bpp_e b);
    case (b)
      BPP_1:   return 5'd31;
      BPP_2:   return 5'd15;
      default: return 5'd7;
    endcase
  endfunction

  // little-endian pixel extraction, zero-extended to 4 bits
  function automatic logic [3:0] pick_pixel(logic [31:0] w, bpp_e b, logic [4:0] pos);
    case (b)
      BPP_1:   return {3'b000, w[pos]};
      BPP_2:   return {2'b00, w[{pos[3:0], 1'b0} +: 2]};
      default: return w[{pos[2:0], 2'b00} +: 4];
    endcase
  endfunction

  // sixteen 4-bit entries packed in a 64-bit table
  function automatic logic [3:0] pal_entry(logic [63:0] tbl, logic [3:0] code);
    return tbl[{code, 2'b00} +: 4];
  endfunction

endpackage

// File: rtl/lcd_word_fifo.sv
module lcd_word_fifo #(
  parameter int DEPTH = 9,
  parameter int W     = 32,
  localparam int AW   = (DEPTH > 1) ? $clog2(DEPTH) : 1,
  localparam int CW   = $clog2(DEPTH + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          flush,
  input  logic          push,
  input  logic [W-1:0]  din,
  input  logic          pop,
  output logic [W-1:0]  head,
  output logic [CW-1:0] level,
  output logic          empty
);
  localparam logic [AW-1:0] LAST_SLOT = AW'(DEPTH - 1);
  localparam logic [CW-1:0] FULL_LVL  = CW'(DEPTH);

  logic [W-1:0]  mem [DEPTH];
  logic [AW-1:0] wr_ptr, rd_ptr;
  logic          push_ok, pop_ok;

  assign empty   = (level == '0);
  assign push_ok = push && (level != FULL_LVL);
  assign pop_ok  = pop && !empty;
  assign head    = mem[rd_ptr];

  always_ff @(posedge clk) begin
    if (push_ok) mem[wr_ptr] <= din;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_ptr <= '0;
      rd_ptr <= '0;
      level  <= '0;
    end else if (flush) begin
      wr_ptr <= '0;
      rd_ptr <= '0;
      level  <= '0;
    end else begin
      if (push_ok) wr_ptr <= (wr_ptr == LAST_SLOT) ? '0 : wr_ptr + 1'b1;
      if (pop_ok)  rd_ptr <= (rd_ptr == LAST_SLOT) ? '0 : rd_ptr + 1'b1;
      case ({push_ok, pop_ok})
        2'b10:   level <= level + 1'b1;
        2'b01:   level <= level - 1'b1;
        default: level <= level;
      endcase
    end
  end
endmodule

// File: rtl/lcd_unpacker.sv
module lcd_unpacker
  import lcd_pix_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic        en,
  input  bpp_e        bpp,
  input  logic        adv,
  input  logic        empty,
  input  logic [31:0] head,
  output logic [3:0]  pix,
  output logic        pop,
  output logic [4:0]  pos,
  output logic        underrun
);
  logic at_last, starve;

  assign at_last = (pos == last_pos(bpp));
  assign pop     = en && adv && !empty && at_last;
  assign starve  = en && adv && empty;
  assign pix     = empty ? 4'd0 : pick_pixel(head, bpp, pos);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pos      <= '0;
      underrun <= 1'b0;
    end else begin
      if (!en)                 pos <= '0;
      else if (adv && !empty)  pos <= at_last ? 5'd0 : pos + 5'd1;
      if (starve) underrun <= 1'b1;
    end
  end
endmodule

// File: rtl/lcd_gray_map.sv
module lcd_gray_map
  import lcd_pix_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic        lo_we,
  input  logic [31:0] lo_d,
  input  logic        hi_we,
  input  logic [31:0] hi_d,
  input  logic        snooze,
  input  logic        pix_ok,
  input  logic [3:0]  pix,
  output logic [3:0]  gray
);
  logic [31:0] pal_lo, pal_hi;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pal_lo <= '0;
      pal_hi <= '0;
    end else begin
      if (lo_we) pal_lo <= lo_d;
      if (hi_we) pal_hi <= hi_d;
    end
  end

  always_comb begin
    if (!pix_ok)     gray = 4'd0;
    else if (snooze) gray = pix;
    else             gray = pal_entry({pal_hi, pal_lo}, pix);
  end
endmodule

// File: rtl/lcd_pixfetch.sv
module lcd_pixfetch
  import lcd_pix_pkg::*;
#(
  parameter int DEPTH    = 9,
  parameter int LOW_MARK = 5,
  localparam int CW      = $clog2(DEPTH + 1)
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        cfg_we,
  input  logic        cfg_enable,
  input  logic [1:0]  cfg_bpp,
  input  logic        pal_lo_we,
  input  logic [31:0] pal_lo_data,
  input  logic        pal_hi_we,
  input  logic [31:0] pal_hi_data,
  input  logic        snooze,
  input  logic        wr_valid,
  input  logic [31:0] wr_data,
  output logic        dma_req,
  input  logic        pix_adv,
  output logic [3:0]  gray,
  output logic        underrun
);
  localparam logic [CW-1:0] LOW_LVL = CW'(LOW_MARK);

  logic          ctl_en;
  bpp_e          ctl_bpp;
  logic [CW-1:0] fifo_cnt;
  logic          fifo_empty;
  logic [31:0]   head_word;
  logic          pop_evt;
  logic [4:0]    pix_idx;
  logic [3:0]    raw_pix;

  // control word: depth only writable while disabled
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctl_en  <= 1'b0;
      ctl_bpp <= BPP_1;
    end else if (cfg_we) begin
      ctl_en <= cfg_enable;
      if (!ctl_en) ctl_bpp <= bpp_e'(cfg_bpp);
    end
  end

  lcd_word_fifo #(.DEPTH(DEPTH), .W(32)) u_fifo (
    .clk   (clk),
    .rst_n (rst_n),
    .flush (!ctl_en),
    .push  (wr_valid && ctl_en),
    .din   (wr_data),
    .pop   (pop_evt),
    .head  (head_word),
    .level (fifo_cnt),
    .empty (fifo_empty)
  );

  lcd_unpacker u_unpack (
    .clk      (clk),
    .rst_n    (rst_n),
    .en       (ctl_en),
    .bpp      (ctl_bpp),
    .adv      (pix_adv),
    .empty    (fifo_empty),
    .head     (head_word),
    .pix      (raw_pix),
    .pop      (pop_evt),
    .pos      (pix_idx),
    .underrun (underrun)
  );

  lcd_gray_map u_map (
    .clk    (clk),
    .rst_n  (rst_n),
    .lo_we  (pal_lo_we),
    .lo_d   (pal_lo_data),
    .hi_we  (pal_hi_we),
    .hi_d   (pal_hi_data),
    .snooze (snooze),
    .pix_ok (ctl_en && !fifo_empty),
    .pix    (raw_pix),
    .gray   (gray)
  );

  assign dma_req = ctl_en && (fifo_cnt <= LOW_LVL);
endmodule

// File: rtl/lcd_pixfetch_chk.sv
module lcd_pixfetch_chk #(
  parameter int DEPTH = 9,
  localparam int CW   = $clog2(DEPTH + 1)
) (
  input logic          clk,
  input logic          rst_n,
  input logic          en,
  input logic [1:0]    bpp,
  input logic [CW-1:0] cnt,
  input logic [4:0]    idx,
  input logic          pop,
  input logic          dma_req,
  input logic [3:0]    gray,
  input logic          underrun
);
  // R2
  fifo_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cnt <= CW'(DEPTH));

  // R3
  req_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !en |-> !dma_req);

  // R3
  req_empty_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (en && cnt == '0) |-> dma_req);

  // R9
  bpp_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    en |=> $stable(bpp));

  // R10
  pop_wrap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    pop |=> (idx == 5'd0));

  // R11
  empty_gray_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cnt == '0) |-> (gray == 4'd0));

  // R11
  underrun_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    underrun |=> underrun);

  // R12
  flush_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !en |=> (cnt == '0 && idx == 5'd0));
endmodule

bind lcd_pixfetch lcd_pixfetch_chk #(.DEPTH(DEPTH)) u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .en       (ctl_en),
  .bpp      (ctl_bpp),
  .cnt      (fifo_cnt),
  .idx      (pix_idx),
  .pop      (pop_evt),
  .dma_req  (dma_req),
  .gray     (gray),
  .underrun (underrun)
);

// File: tb/lcd_pixfetch_tb.sv
`timescale 1ns/1ps
module lcd_pixfetch_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cfg_we = 1'b0, cfg_enable = 1'b0;
  logic [1:0]  cfg_bpp = 2'b00;
  logic        pal_lo_we = 1'b0, pal_hi_we = 1'b0;
  logic [31:0] pal_lo_data = '0, pal_hi_data = '0;
  logic        snooze = 1'b0;
  logic        wr_valid = 1'b0;
  logic [31:0] wr_data = '0;
  logic        dma_req;
  logic        pix_adv = 1'b0;
  logic [3:0]  gray;
  logic        underrun;

  int n_checks = 0;
  int n_fail   = 0;
  bit done     = 1'b0;
  logic [3:0] exp_q[$];
  string      tag_q[$];

  always #2.5 clk = ~clk;

  lcd_pixfetch u_dut (.*);

  task automatic check(input bit ok, input string req, input int act, input int exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic step();
    @(posedge clk); #1;
  endtask

  task automatic cfg(input bit en, input logic [1:0] code);
    step(); cfg_we = 1'b1; cfg_enable = en; cfg_bpp = code;
    step(); cfg_we = 1'b0;
  endtask

  task automatic raw_write(input logic [31:0] w);
    step(); wr_valid = 1'b1; wr_data = w;
    step(); wr_valid = 1'b0;
  endtask

  // driver: write a word and queue the gray levels it should produce
  // palette used below holds 15-n in entry n
  task automatic push_word(input logic [31:0] w, input int nbits, input bit snz, input string req);
    logic [31:0] sh;
    sh = w;
    for (int k = 0; k < 32 / nbits; k++) begin
      int p;
      p = int'(sh) & ((1 << nbits) - 1);
      sh = sh >> nbits;
      exp_q.push_back(snz ? 4'(p) : 4'(15 - p));
      tag_q.push_back(req);
    end
    raw_write(w);
  endtask

  task automatic drain(input int n);
    step(); pix_adv = 1'b1;
    repeat (n) @(posedge clk);
    #1 pix_adv = 1'b0;
  endtask

  // monitor: compare each consumed pixel with the scoreboard
  always @(negedge clk) begin
    if (rst_n && pix_adv) begin
      logic [3:0] e;
      string r;
      if (exp_q.size() > 0) begin
        e = exp_q.pop_front();
        r = tag_q.pop_front();
      end else begin
        e = 4'd0;
        r = "R11";
      end
      check(gray == e, r, gray, e);
    end
  end

  task automatic at_neg();
    @(negedge clk);
  endtask

  initial begin
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    at_neg();
    // R1
    check(dma_req == 1'b0, "R1", dma_req, 0);
    check(gray == 4'd0, "R1", gray, 0);
    check(underrun == 1'b0, "R1", underrun, 0);

    // R7 palette: entry n = 15-n
    step(); pal_lo_we = 1'b1; pal_lo_data = 32'h89AB_CDEF;
    pal_hi_we = 1'b1; pal_hi_data = 32'h0123_4567;
    step(); pal_lo_we = 1'b0; pal_hi_we = 1'b0;

    cfg(1'b1, 2'b10);
    at_neg();
    check(dma_req == 1'b1, "R3", dma_req, 1);

    // fill to capacity at 4 bpp (R6, R7)
    for (int i = 0; i < 9; i++)
      push_word(32'h7654_3210 ^ (i * 32'h0101_1011), 4, 1'b0, "R7");
    at_neg();
    check(dma_req == 1'b0, "R3", dma_req, 0);
    // R2: tenth word dropped (its pixel 0 would map to gray 5)
    raw_write(32'hAAAA_AAAA);
    drain(24);
    at_neg();
    check(dma_req == 1'b0, "R3", dma_req, 0);
    drain(8);
    at_neg();
    check(dma_req == 1'b1, "R3", dma_req, 1);
    drain(40);
    at_neg();
    check(underrun == 1'b0, "R11", underrun, 0);
    check(gray == 4'd0, "R2", gray, 0);
    drain(1);
    at_neg();
    check(underrun == 1'b1, "R11", underrun, 1);

    // R9: depth write while enabled ignored, stays at 4 bpp
    cfg(1'b1, 2'b00);
    push_word(32'hFEDC_BA98, 4, 1'b0, "R9");
    drain(8);

    // R12: partial word then disable
    push_word(32'h1357_9BDF, 4, 1'b0, "R12");
    push_word(32'h2468_ACE0, 4, 1'b0, "R12");
    drain(3);
    cfg(1'b0, 2'b00);
    exp_q.delete();
    tag_q.delete();
    at_neg();
    check(dma_req == 1'b0, "R12", dma_req, 0);
    check(gray == 4'd0, "R12", gray, 0);

    // R4, R5, R10: 1 bpp across a word boundary, starting at bit 0
    cfg(1'b1, 2'b00);
    push_word(32'h8000_0001, 1, 1'b0, "R4");
    push_word(32'h5A5A_0FF0, 1, 1'b0, "R10");
    drain(64);

    // R5, R10: 2 bpp
    cfg(1'b0, 2'b00);
    cfg(1'b1, 2'b01);
    push_word(32'hE4E4_1B1B, 2, 1'b0, "R5");
    push_word(32'h0F0F_C3C3, 2, 1'b0, "R10");
    drain(32);

    // R8: snooze bypass at 2 bpp, then R6 code 2'b11 at 4 bpp
    snooze = 1'b1;
    push_word(32'h9C63_E41B, 2, 1'b1, "R8");
    drain(16);
    cfg(1'b0, 2'b00);
    cfg(1'b1, 2'b11);
    push_word(32'hC0FF_EE51, 4, 1'b1, "R6");
    drain(8);
    snooze = 1'b0;

    cfg(1'b0, 2'b00);
    at_neg();
    check(underrun == 1'b1, "R11", underrun, 1);
    check(exp_q.size() == 0, "R10", exp_q.size(), 0);

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end

  initial begin
    #(200000 * 5);
    if (!done) begin
      n_fail++;
      n_checks++;
      $display("FAIL watchdog: actual 0 expected 1");
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
      $finish;
    end
  end
endmodule